// File: doc/BRIEF.md
# PCIe Root Port Interrupt Collector

This block gathers the interrupt-class events that a PCIe root port has already decoded and turns them into one level interrupt for the host. The events are legacy line interrupts (an assert or deassert pulse for each of four lines), message-signalled interrupts (a 64-bit write address with a 16-bit payload), a power-state-change pulse and a flush pulse. Each event sets a sticky bit in a status register. Software reads and clears these bits through a 32-bit register port.

The status registers form a tree with two levels. The 32 message vectors collapse into one pending bit of the primary status register. The primary and secondary status registers then collapse into the core bit of the host status register. The host status register, gated by its own mask, drives `irqOut`. At every level a status bit is cleared by writing 1 to it, and a mask bit set to 1 keeps that source out of the level above. Decoding the messages out of packets is done elsewhere and is not part of this block.

Top module: `pcie_irq_collector`

## Requirements
- R1: After reset every status register, the MSI address pair and the payload register read 0. The primary mask reads 0x07FFFFFF, the secondary mask reads 0x00000030, the MSI mask reads 0xFFFFFFFF and the host mask reads 0x00FFF0FB. `irqOut` is low.
- R2: An assert pulse on line n (0..3) sets primary status bit 16+n on the next clock edge. A deassert pulse on line n sets bit 20+n.
- R3: A message write is taken only when `msiAddr` equals {address-high register, address-low register}. When it is taken, MSI status bit `msiData[4:0]` is set and the payload register loads `msiData[7:0]`. A message with any other address changes nothing.
- R4: Primary bit 24 is set one cycle after any MSI status bit is set whose MSI mask bit is 0. A vector whose mask bit is 1 never sets bit 24.
- R5: A power-state-change pulse sets secondary bit 4, and a flush pulse sets secondary bit 5.
- R6: Writing to a status register clears exactly the bits written as 1. Bits written as 0 keep their value.
- R7: If a status bit is cleared by software and set by an event in the same cycle, the bit ends up set.
- R8: Host status bit 16 is set one cycle after (primary & ~primary mask) or (secondary & ~secondary mask) is nonzero.
- R9: `irqOut` is high exactly when host status bit 16 is set and host mask bit 16 is 0.
- R10: Word offsets: 0 primary status, 1 primary mask, 2 secondary status, 3 secondary mask, 4 MSI address low, 5 MSI address high, 6 MSI status, 7 MSI mask, 8 payload (read only), 9 host status, 10 host mask. A mask register keeps only its valid bits (primary [26:0], secondary [5:4], host 0xFFF0FB). Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| intxAssert | input | 4 | One-cycle assert pulse for each legacy line |
| intxDeassert | input | 4 | One-cycle deassert pulse for each legacy line |
| msiValid | input | 1 | A message write is present this cycle |
| msiAddr | input | 64 | Target address of the message write |
| msiData | input | 16 | Payload of the message write |
| powerEvent | input | 1 | Power-state-change pulse |
| flushEvent | input | 1 | Flush pulse |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register word offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| irqOut | output | 1 | Summary interrupt |

## Verification
A software clear and a hardware event can land on the same status bit in the same cycle. The bench provokes this in two ways. First, it drives a clear of primary bit 16 together with an assert pulse on line 0. Second, it clears primary bit 24 while an unmasked MSI vector is still pending, which keeps setting the bit. A behavioural model steps beside the design on every clock. It expects the bit to survive in both cases and to drop once its source is gone, and it compares `irqOut` on every cycle. A register read-back then confirms the result.

// File: rtl/irq_collector_pkg.sv
package irq_collector_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [3:0] {
    SEL_PRI_STAT  = 4'd0,
    SEL_PRI_MASK  = 4'd1,
    SEL_SEC_STAT  = 4'd2,
    SEL_SEC_MASK  = 4'd3,
    SEL_ADDR_LO   = 4'd4,
    SEL_ADDR_HI   = 4'd5,
    SEL_MSI_STAT  = 4'd6,
    SEL_MSI_MASK  = 4'd7,
    SEL_MSI_DATA  = 4'd8,
    SEL_HOST_STAT = 4'd9,
    SEL_HOST_MASK = 4'd10,
    SEL_NONE      = 4'd15
  } regSel_e;

  localparam logic [DATA_W-1:0] PRI_VALID  = 32'h07FF_FFFF;
  localparam logic [DATA_W-1:0] SEC_VALID  = 32'h0000_0030;
  localparam logic [DATA_W-1:0] HOST_VALID = 32'h00FF_F0FB;

  localparam int PRI_ASSERT_LSB   = 16;
  localparam int PRI_DEASSERT_LSB = 20;
  localparam int PRI_MSI_BIT      = 24;
  localparam int SEC_POWER_BIT    = 4;
  localparam int SEC_FLUSH_BIT    = 5;
  localparam int HOST_CORE_BIT    = 16;

  typedef struct packed {
    logic    priClr;
    logic    priMaskWr;
    logic    secClr;
    logic    secMaskWr;
    logic    addrLoWr;
    logic    addrHiWr;
    logic    msiClr;
    logic    msiMaskWr;
    logic    hostClr;
    logic    hostMaskWr;
    logic    msiHit;
    regSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/irq_collector_ctrl.sv
module irq_collector_ctrl
  import irq_collector_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          regWrEn,
  input  logic [AW-1:0] regAddr,
  input  logic          msiValid,
  input  logic [63:0]   msiAddr,
  input  logic [63:0]   msiTarget,
  output ctrlStrobes_t  strobes
);

  always_comb begin
    strobes        = '0;
    strobes.rdSel  = SEL_NONE;
    strobes.msiHit = msiValid && (msiAddr == msiTarget);
    case (regAddr)
      AW'(SEL_PRI_STAT):  begin strobes.rdSel = SEL_PRI_STAT;  strobes.priClr     = regWrEn; end
      AW'(SEL_PRI_MASK):  begin strobes.rdSel = SEL_PRI_MASK;  strobes.priMaskWr  = regWrEn; end
      AW'(SEL_SEC_STAT):  begin strobes.rdSel = SEL_SEC_STAT;  strobes.secClr     = regWrEn; end
      AW'(SEL_SEC_MASK):  begin strobes.rdSel = SEL_SEC_MASK;  strobes.secMaskWr  = regWrEn; end
      AW'(SEL_ADDR_LO):   begin strobes.rdSel = SEL_ADDR_LO;   strobes.addrLoWr   = regWrEn; end
      AW'(SEL_ADDR_HI):   begin strobes.rdSel = SEL_ADDR_HI;   strobes.addrHiWr   = regWrEn; end
      AW'(SEL_MSI_STAT):  begin strobes.rdSel = SEL_MSI_STAT;  strobes.msiClr     = regWrEn; end
      AW'(SEL_MSI_MASK):  begin strobes.rdSel = SEL_MSI_MASK;  strobes.msiMaskWr  = regWrEn; end
      AW'(SEL_MSI_DATA):  begin strobes.rdSel = SEL_MSI_DATA; end
      AW'(SEL_HOST_STAT): begin strobes.rdSel = SEL_HOST_STAT; strobes.hostClr    = regWrEn; end
      AW'(SEL_HOST_MASK): begin strobes.rdSel = SEL_HOST_MASK; strobes.hostMaskWr = regWrEn; end
      default:            strobes.rdSel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/irq_collector_dpath.sv
module irq_collector_dpath
  import irq_collector_pkg::*;
#(
  parameter int NUM_INTX = 4,
  parameter int NUM_MSI  = 32,
  localparam int MSI_VW  = $clog2(NUM_MSI)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobes_t        strobes,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_INTX-1:0] intxAssert,
  input  logic [NUM_INTX-1:0] intxDeassert,
  input  logic [15:0]         msiData,
  input  logic                powerEvent,
  input  logic                flushEvent,
  output logic [63:0]         msiTarget,
  output logic [DATA_W-1:0]   rdData,
  output logic                irqOut,
  output logic [DATA_W-1:0]   priStat,
  output logic [DATA_W-1:0]   priMask,
  output logic [DATA_W-1:0]   secStat,
  output logic [DATA_W-1:0]   secMask,
  output logic [NUM_MSI-1:0]  msiStat,
  output logic [NUM_MSI-1:0]  msiMask,
  output logic                hostCore,
  output logic [DATA_W-1:0]   hostMask
);

  logic [DATA_W-1:0] priSet, secSet, priClrVec, secClrVec, hostStatVec;
  logic [31:0]       targetLo, targetHi;
  logic [7:0]        payload;
  logic [MSI_VW-1:0] msiVec;
  logic              msiPending, coreSet;

  assign msiTarget  = {targetHi, targetLo};
  assign msiVec     = msiData[MSI_VW-1:0];
  assign msiPending = |(msiStat & ~msiMask);
  assign coreSet    = (|(priStat & ~priMask)) || (|(secStat & ~secMask));
  assign priClrVec  = strobes.priClr ? wrData : '0;
  assign secClrVec  = strobes.secClr ? wrData : '0;

  always_comb begin
    priSet = '0;
    priSet[PRI_ASSERT_LSB +: NUM_INTX]   = intxAssert;
    priSet[PRI_DEASSERT_LSB +: NUM_INTX] = intxDeassert;
    priSet[PRI_MSI_BIT]                  = msiPending;
    secSet = '0;
    secSet[SEC_POWER_BIT] = powerEvent;
    secSet[SEC_FLUSH_BIT] = flushEvent;
  end

  // status: the clear applies first, then new events are ORed in, so an event wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priStat  <= '0;
      secStat  <= '0;
      hostCore <= 1'b0;
    end else begin
      priStat  <= ((priStat & ~priClrVec) | priSet) & PRI_VALID;
      secStat  <= ((secStat & ~secClrVec) | secSet) & SEC_VALID;
      hostCore <= (hostCore && !(strobes.hostClr && wrData[HOST_CORE_BIT])) || coreSet;
    end
  end

  // one flop per message vector
  for (genvar v = 0; v < NUM_MSI; v++) begin : g_msiVec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        msiStat[v] <= 1'b0;
      else if (strobes.msiHit && (msiVec == MSI_VW'(v)))
        msiStat[v] <= 1'b1;
      else if (strobes.msiClr && wrData[v])
        msiStat[v] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priMask  <= PRI_VALID;
      secMask  <= SEC_VALID;
      msiMask  <= '1;
      hostMask <= HOST_VALID;
      targetLo <= '0;
      targetHi <= '0;
      payload  <= '0;
    end else begin
      if (strobes.priMaskWr)  priMask  <= wrData & PRI_VALID;
      if (strobes.secMaskWr)  secMask  <= wrData & SEC_VALID;
      if (strobes.msiMaskWr)  msiMask  <= wrData[NUM_MSI-1:0];
      if (strobes.hostMaskWr) hostMask <= wrData & HOST_VALID;
      if (strobes.addrLoWr)   targetLo <= wrData;
      if (strobes.addrHiWr)   targetHi <= wrData;
      if (strobes.msiHit)     payload  <= msiData[7:0];
    end
  end

  always_comb begin
    hostStatVec = '0;
    hostStatVec[HOST_CORE_BIT] = hostCore;
  end

  assign irqOut = |(hostStatVec & ~hostMask & HOST_VALID);

  always_comb begin
    case (strobes.rdSel)
      SEL_PRI_STAT:  rdData = priStat;
      SEL_PRI_MASK:  rdData = priMask;
      SEL_SEC_STAT:  rdData = secStat;
      SEL_SEC_MASK:  rdData = secMask;
      SEL_ADDR_LO:   rdData = targetLo;
      SEL_ADDR_HI:   rdData = targetHi;
      SEL_MSI_STAT:  rdData = DATA_W'(msiStat);
      SEL_MSI_MASK:  rdData = DATA_W'(msiMask);
      SEL_MSI_DATA:  rdData = DATA_W'(payload);
      SEL_HOST_STAT: rdData = hostStatVec;
      SEL_HOST_MASK: rdData = hostMask;
      default:       rdData = '0;
    endcase
  end

endmodule

// File: rtl/pcie_irq_collector.sv
module pcie_irq_collector
  import irq_collector_pkg::*;
#(
  parameter int REG_AW   = 4,
  parameter int NUM_INTX = 4,
  parameter int NUM_MSI  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_INTX-1:0] intxAssert,
  input  logic [NUM_INTX-1:0] intxDeassert,
  input  logic                msiValid,
  input  logic [63:0]         msiAddr,
  input  logic [15:0]         msiData,
  input  logic                powerEvent,
  input  logic                flushEvent,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  output logic [DATA_W-1:0]   regRdData,
  output logic                irqOut
);

  ctrlStrobes_t       strobes;
  logic [63:0]        msiTarget;
  logic [DATA_W-1:0]  priStat, priMask, secStat, secMask, hostMask;
  logic [NUM_MSI-1:0] msiStat, msiMask;
  logic               hostCore;

  irq_collector_ctrl #(.AW(REG_AW)) u_ctrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .msiValid  (msiValid),
    .msiAddr   (msiAddr),
    .msiTarget (msiTarget),
    .strobes   (strobes)
  );

  irq_collector_dpath #(.NUM_INTX(NUM_INTX), .NUM_MSI(NUM_MSI)) u_dpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .strobes      (strobes),
    .wrData       (regWrData),
    .intxAssert   (intxAssert),
    .intxDeassert (intxDeassert),
    .msiData      (msiData),
    .powerEvent   (powerEvent),
    .flushEvent   (flushEvent),
    .msiTarget    (msiTarget),
    .rdData       (regRdData),
    .irqOut       (irqOut),
    .priStat      (priStat),
    .priMask      (priMask),
    .secStat      (secStat),
    .secMask      (secMask),
    .msiStat      (msiStat),
    .msiMask      (msiMask),
    .hostCore     (hostCore),
    .hostMask     (hostMask)
  );

endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk
  import irq_collector_pkg::*;
#(
  parameter int REG_AW   = 4,
  parameter int NUM_INTX = 4,
  parameter int NUM_MSI  = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_INTX-1:0] intxAssert,
  input logic                powerEvent,
  input logic                regWrEn,
  input logic [REG_AW-1:0]   regAddr,
  input logic [DATA_W-1:0]   regWrData,
  input logic [DATA_W-1:0]   priStat,
  input logic [DATA_W-1:0]   priMask,
  input logic [DATA_W-1:0]   secStat,
  input logic [DATA_W-1:0]   secMask,
  input logic [NUM_MSI-1:0]  msiStat,
  input logic [NUM_MSI-1:0]  msiMask,
  input logic                hostCore,
  input logic [DATA_W-1:0]   hostMask,
  input logic                irqOut
);

  logic priClrHit;
  assign priClrHit = regWrEn && (regAddr == REG_AW'(SEL_PRI_STAT)) && regWrData[PRI_ASSERT_LSB];

  a_r2_assert_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    intxAssert[0] |=> priStat[PRI_ASSERT_LSB]);

  a_r5_power_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    powerEvent |=> secStat[SEC_POWER_BIT]);

  a_r4_msi_folds: assert property (@(posedge clk) disable iff (!rst_n)
    (|(msiStat & ~msiMask)) |=> priStat[PRI_MSI_BIT]);

  a_r8_core_folds: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(priStat & ~priMask)) || (|(secStat & ~secMask))) |=> hostCore);

  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irqOut |-> (hostCore && !hostMask[HOST_CORE_BIT]));

  a_r6_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (priClrHit && !intxAssert[0]) |=> !priStat[PRI_ASSERT_LSB]);

  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (priClrHit && intxAssert[0]) |=> priStat[PRI_ASSERT_LSB]);

endmodule

bind pcie_irq_collector irq_collector_chk #(
  .REG_AW(REG_AW), .NUM_INTX(NUM_INTX), .NUM_MSI(NUM_MSI)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .intxAssert (intxAssert),
  .powerEvent (powerEvent),
  .regWrEn    (regWrEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .priStat    (priStat),
  .priMask    (priMask),
  .secStat    (secStat),
  .secMask    (secMask),
  .msiStat    (msiStat),
  .msiMask    (msiMask),
  .hostCore   (hostCore),
  .hostMask   (hostMask),
  .irqOut     (irqOut)
);

// File: tb/pcie_irq_collector_tb.sv
module pcie_irq_collector_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  intxAssert, intxDeassert;
  logic        msiValid;
  logic [63:0] msiAddr;
  logic [15:0] msiData;
  logic        powerEvent, flushEvent;
  logic        regWrEn;
  logic [3:0]  regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  pcie_irq_collector u_dut (
    .clk(clk), .rst_n(rst_n), .intxAssert(intxAssert), .intxDeassert(intxDeassert),
    .msiValid(msiValid), .msiAddr(msiAddr), .msiData(msiData),
    .powerEvent(powerEvent), .flushEvent(flushEvent), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  // behavioural reference model
  logic [31:0] mPri, mPriMask, mSec, mSecMask, mMsi, mMsiMask, mLo, mHi, mHostMask;
  logic [7:0]  mPay;
  logic        mHost;

  always @(posedge clk) begin
    logic pend, core, hit;
    if (!rst_n) begin
      mPri = 0; mSec = 0; mMsi = 0; mLo = 0; mHi = 0; mPay = 0; mHost = 0;
      mPriMask = 32'h07FF_FFFF; mSecMask = 32'h30; mMsiMask = 32'hFFFF_FFFF;
      mHostMask = 32'h00FF_F0FB;
    end else begin
      pend = (mMsi & ~mMsiMask) != 0;
      core = ((mPri & ~mPriMask) != 0) || ((mSec & ~mSecMask) != 0);
      hit  = msiValid && (msiAddr == {mHi, mLo});
      if (regWrEn) begin
        case (regAddr)
          4'd0:  mPri = mPri & ~regWrData;
          4'd1:  mPriMask = regWrData & 32'h07FF_FFFF;
          4'd2:  mSec = mSec & ~regWrData;
          4'd3:  mSecMask = regWrData & 32'h30;
          4'd4:  mLo = regWrData;
          4'd5:  mHi = regWrData;
          4'd6:  mMsi = mMsi & ~regWrData;
          4'd7:  mMsiMask = regWrData;
          4'd9:  if (regWrData[16]) mHost = 0;
          4'd10: mHostMask = regWrData & 32'h00FF_F0FB;
          default: ;
        endcase
      end
      for (int n = 0; n < 4; n++) begin
        if (intxAssert[n])   mPri[16+n] = 1'b1;
        if (intxDeassert[n]) mPri[20+n] = 1'b1;
      end
      if (pend) mPri[24] = 1'b1;
      if (powerEvent) mSec[4] = 1'b1;
      if (flushEvent) mSec[5] = 1'b1;
      if (hit) begin
        mMsi[msiData[4:0]] = 1'b1;
        mPay = msiData[7:0];
      end
      if (core) mHost = 1'b1;
    end
  end

  function automatic logic [31:0] mRead(input logic [3:0] a);
    case (a)
      4'd0: return mPri;      4'd1: return mPriMask;
      4'd2: return mSec;      4'd3: return mSecMask;
      4'd4: return mLo;       4'd5: return mHi;
      4'd6: return mMsi;      4'd7: return mMsiMask;
      4'd8: return {24'd0, mPay};
      4'd9: return {15'd0, mHost, 16'd0};
      4'd10: return mHostMask;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-cycle summary comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1)
      check({31'd0, irqOut}, {31'd0, mHost && !mHostMask[16]}, "R9 irqOut per cycle");
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    regAddr = a;
    #1;
    check(regRdData, exp, tag);
    check(exp, mRead(a), {tag, " (model)"});
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0; regWrData = 0;
  endtask

  task automatic sendMsi(input logic [63:0] a, input logic [15:0] d);
    msiValid = 1; msiAddr = a; msiData = d;
    @(negedge clk);
    msiValid = 0; msiAddr = 0; msiData = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; intxAssert = 0; intxDeassert = 0; msiValid = 0; msiAddr = 0;
    msiData = 0; powerEvent = 0; flushEvent = 0; regWrEn = 0; regAddr = 0; regWrData = 0;
    idle(3);
    rst_n = 1;
    idle(1);

    // R1 reset state
    rd(4'd0, 32'h0, "R1 primary status");
    rd(4'd1, 32'h07FF_FFFF, "R1 primary mask");
    rd(4'd2, 32'h0, "R1 secondary status");
    rd(4'd3, 32'h30, "R1 secondary mask");
    rd(4'd4, 32'h0, "R1 address low");
    rd(4'd6, 32'h0, "R1 msi status");
    rd(4'd7, 32'hFFFF_FFFF, "R1 msi mask");
    rd(4'd8, 32'h0, "R1 payload");
    rd(4'd9, 32'h0, "R1 host status");
    rd(4'd10, 32'h00FF_F0FB, "R1 host mask");
    check({31'd0, irqOut}, 32'd0, "R1 irqOut low");

    // R10 map and valid-bit masking
    wr(4'd10, 32'hFFFF_FFFF);
    rd(4'd10, 32'h00FF_F0FB, "R10 host mask valid bits");
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, 32'h30, "R10 secondary mask valid bits");
    rd(4'd12, 32'h0, "R10 unmapped offset");
    wr(4'd1, 0); wr(4'd3, 0); wr(4'd7, 0); wr(4'd10, 0);
    rd(4'd1, 32'h0, "R10 primary mask written");

    // R2 legacy lines
    intxAssert = 4'b0100; @(negedge clk); intxAssert = 0;
    rd(4'd0, 32'h0004_0000, "R2 assert line 2");
    intxDeassert = 4'b1000; @(negedge clk); intxDeassert = 0;
    rd(4'd0, 32'h0084_0000, "R2 deassert line 3");
    idle(2);
    rd(4'd9, 32'h0001_0000, "R8 host core set");
    check({31'd0, irqOut}, 32'd1, "R9 irqOut high");

    // R6 write-one-to-clear
    wr(4'd0, 32'h0);
    rd(4'd0, 32'h0084_0000, "R6 zero write keeps bits");
    wr(4'd0, 32'h0004_0000);
    rd(4'd0, 32'h0080_0000, "R6 partial clear");
    wr(4'd0, 32'h0080_0000);
    idle(1);
    wr(4'd9, 32'h0001_0000);
    rd(4'd9, 32'h0, "R6 host clear");

    // R3 address match
    sendMsi(64'h0000_0000_0000_1234, 16'h0003);
    rd(4'd6, 32'h0, "R3 wrong address ignored");
    wr(4'd4, 32'hFEE0_0000); wr(4'd5, 32'h1);
    sendMsi(64'h0000_0002_FEE0_0000, 16'h0003);
    rd(4'd6, 32'h0, "R3 wrong high half ignored");
    sendMsi(64'h0000_0001_FEE0_0000, 16'h01A5);
    rd(4'd6, 32'h0000_0020, "R3 vector 5 set");
    rd(4'd8, 32'h0000_00A5, "R3 payload low byte");
    idle(1);
    rd(4'd0, 32'h0100_0000, "R4 msi pending bit");

    // R7 clear while the MSI source is still pending
    wr(4'd0, 32'h0100_0000);
    rd(4'd0, 32'h0100_0000, "R7 pending survives clear");
    wr(4'd6, 32'h20);
    wr(4'd0, 32'h0100_0000);
    rd(4'd0, 32'h0, "R6 pending cleared after source");
    // R7 same-cycle clear and assert on line 0
    regWrEn = 1; regAddr = 4'd0; regWrData = 32'h0001_0000; intxAssert = 4'b0001;
    @(negedge clk);
    regWrEn = 0; regWrData = 0; intxAssert = 0;
    rd(4'd0, 32'h0001_0000, "R7 event beats clear");
    wr(4'd0, 32'h0001_0000);
    rd(4'd0, 32'h0, "R6 line 0 cleared");

    // R4 masked vector
    idle(1);
    wr(4'd9, 32'h0001_0000);
    wr(4'd7, 32'h80);
    sendMsi(64'h0000_0001_FEE0_0000, 16'h0007);
    idle(2);
    rd(4'd6, 32'h80, "R4 masked vector recorded");
    rd(4'd0, 32'h0, "R4 masked vector does not fold");
    wr(4'd6, 32'h80);

    // R5 secondary events
    powerEvent = 1; @(negedge clk); powerEvent = 0;
    rd(4'd2, 32'h10, "R5 power change");
    flushEvent = 1; @(negedge clk); flushEvent = 0;
    rd(4'd2, 32'h30, "R5 flush");
    wr(4'd2, 32'h10);
    rd(4'd2, 32'h20, "R6 secondary partial clear");

    // R8 masked secondary keeps the core bit clear; R9 host mask gates output
    wr(4'd3, 32'h20);
    idle(1);
    wr(4'd9, 32'h0001_0000);
    idle(2);
    rd(4'd9, 32'h0, "R8 masked source no core");
    wr(4'd3, 32'h0);
    wr(4'd10, 32'h0001_0000);
    idle(2);
    rd(4'd9, 32'h0001_0000, "R8 unmasked source core");
    check({31'd0, irqOut}, 32'd0, "R9 host mask gates irq");
    wr(4'd10, 32'h0);
    idle(1);
    check({31'd0, irqOut}, 32'd1, "R9 unmasked irq");

    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule